// File: doc/BRIEF.md
# Transmit Byte Queue with Status Tags

This block is a first-in, first-out byte queue that sits between a register write port and the reader on the packet-processing side. Each stored location holds one data byte and a small status tag, such as an end-of-packet mark, so a packet boundary travels through the queue with the byte it belongs to. All transfers are whole bytes, and both ports share a single clock.

The writer watches three level indications: `empty`, `full` and `space_avail`. `space_avail` is programmable. It is high while the number of free locations is at least the value on `space_thresh`, so software can write in bursts of a known size. The reader pulses `rd_en` and gets the byte and its tag one clock later, marked by `rd_valid`. A write into a full queue is dropped. A read from an empty queue returns nothing. Each of these misuses sets a sticky error flag (`overflow` or `underflow`), and the flag stays set until `err_clr` is pulsed.

Top module: `txq_byte_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `fill_level` is 0, `empty` is 1, `full` is 0, `rd_valid` is 0, `overflow` is 0 and `underflow` is 0.
- R2: Bytes and their tags leave in the order they were accepted. After an accepted read (`rd_en` high while not empty), `rd_data`, `rd_tag` and `rd_valid`=1 appear in the following cycle. `rd_valid` is 0 in every cycle that does not follow an accepted read.
- R3: A write while `full` is high is discarded: the fill level and the stored contents do not change, and `overflow` reads 1 from the next cycle on.
- R4: A read while `empty` is high returns no data (`rd_valid` stays 0 in the next cycle), and `underflow` reads 1 from the next cycle on.
- R5: `empty` is 1 exactly when `fill_level` is 0, and `full` is 1 exactly when `fill_level` equals DEPTH (256).
- R6: `space_avail` is 1 exactly when DEPTH minus `fill_level` is greater than or equal to `space_thresh`. This includes threshold 0 (always 1) and threshold DEPTH (1 only when empty).
- R7: An accepted write and an accepted read in the same cycle leave `fill_level` unchanged.
- R8: `overflow` and `underflow` stay set until `err_clr` is pulsed. If a new error event and `err_clr` arrive in the same cycle, the flag stays set.
- R9: `fill_level` counts the stored entries, from 0 up to DEPTH inclusive. Each lone accepted write adds one and each lone accepted read subtracts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to store |
| wr_tag | input | 2 | Status tag stored with the byte |
| rd_en | input | 1 | Read strobe from the packet processor |
| rd_data | output | 8 | Byte read out, valid with `rd_valid` |
| rd_tag | output | 2 | Tag of the byte read out |
| rd_valid | output | 1 | High one cycle after an accepted read |
| space_thresh | input | 9 | Free-location threshold for `space_avail` |
| err_clr | input | 1 | Clears both sticky error flags |
| empty | output | 1 | No entries stored |
| space_avail | output | 1 | Free locations at or above the threshold |
| full | output | 1 | No free location left |
| fill_level | output | 9 | Number of stored entries |
| overflow | output | 1 | Sticky: write attempted while full |
| underflow | output | 1 | Sticky: read attempted while empty |

## Verification
The hardest corner to reach is the full boundary: a discarded write, a read paired with a write while full, and an error event that lands in the same cycle as `err_clr`. All three occur only after exactly 256 accepted writes. The stimulus reaches this state by filling the queue with a counted sequence of distinct byte and tag values. It then exercises these cases at the boundary and drains all 256 entries. The drain compares every byte against the bench model, which shows that the discarded writes never replaced stored contents. The threshold is changed during filling and while empty, so `space_avail` is checked at threshold 0, at threshold 256, and one entry away from full.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int TXQ_DATA_W = 8;
  localparam int TXQ_TAG_W  = 2;

  // Kind of queue movement in one cycle, {pop, push}
  typedef enum logic [1:0] {
    TXQ_OP_IDLE = 2'b00,
    TXQ_OP_PUSH = 2'b01,
    TXQ_OP_POP  = 2'b10,
    TXQ_OP_BOTH = 2'b11
  } txq_op_e;

endpackage

// File: rtl/txq_ptr_ctrl.sv
module txq_ptr_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [CW-1:0] space_thresh,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          wr_reject,
  output logic          rd_reject,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          space_avail
);
  import txq_pkg::*;

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_nxt, rd_ptr_nxt;
  logic [CW-1:0] count_nxt;
  logic [CW-1:0] free_slots;
  txq_op_e       op;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + 1'b1;
  endfunction

  // Flags from the current fill count
  always_comb begin
    empty       = (count == '0);
    full        = (count == DEPTH_C);
    free_slots  = DEPTH_C - count;
    space_avail = (free_slots >= space_thresh);
    wr_ok       = wr_en && !full;
    rd_ok       = rd_en && !empty;
    wr_reject   = wr_en && full;
    rd_reject   = rd_en && empty;
  end

  // Next state
  always_comb begin
    op         = txq_op_e'({rd_ok, wr_ok});
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    count_nxt  = count;
    case (op)
      TXQ_OP_PUSH: begin
        wr_ptr_nxt = ptr_step(wr_ptr);
        count_nxt  = count + 1'b1;
      end
      TXQ_OP_POP: begin
        rd_ptr_nxt = ptr_step(rd_ptr);
        count_nxt  = count - 1'b1;
      end
      TXQ_OP_BOTH: begin
        wr_ptr_nxt = ptr_step(wr_ptr);
        rd_ptr_nxt = ptr_step(rd_ptr);
      end
      default: ;
    endcase
  end

  // State registers with the enable written out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (wr_ok || rd_ok) begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 256,
  parameter int W     = 10,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          rvalid
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_nxt;

  // Storage array, no reset
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_nxt = re ? mem[raddr] : rdata;
  end

  // Registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rdata_nxt;
      rvalid <= re;
    end
  end

endmodule

// File: rtl/txq_err_latch.sv
module txq_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_nxt;

  // Set takes priority over clear
  always_comb begin
    flag_nxt = flag_o;
    if (set_i) begin
      flag_nxt = 1'b1;
    end else if (clr_i) begin
      flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (set_i || clr_i) begin
      flag_o <= flag_nxt;
    end
  end

endmodule

// File: rtl/txq_byte_fifo.sv
module txq_byte_fifo #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = txq_pkg::TXQ_DATA_W,
  parameter int TAG_W  = txq_pkg::TXQ_TAG_W,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int EW = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  input  logic [CW-1:0]     space_thresh,
  input  logic              err_clr,
  output logic              empty,
  output logic              space_avail,
  output logic              full,
  output logic [CW-1:0]     fill_level,
  output logic              overflow,
  output logic              underflow
);

  logic          wr_ok, rd_ok, wr_reject, rd_reject;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] rd_entry;
  logic [1:0]    err_set, err_flag;

  txq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .space_thresh (space_thresh),
    .wr_ok        (wr_ok),
    .rd_ok        (rd_ok),
    .wr_reject    (wr_reject),
    .rd_reject    (rd_reject),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .count        (fill_level),
    .empty        (empty),
    .full         (full),
    .space_avail  (space_avail)
  );

  txq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_ok),
    .waddr  (wr_ptr),
    .wdata  ({wr_tag, wr_data}),
    .re     (rd_ok),
    .raddr  (rd_ptr),
    .rdata  (rd_entry),
    .rvalid (rd_valid)
  );

  assign rd_data = rd_entry[DATA_W-1:0];
  assign rd_tag  = rd_entry[EW-1:DATA_W];

  // Error flags: bit 0 overflow, bit 1 underflow
  assign err_set = {rd_reject, wr_reject};

  for (genvar g = 0; g < 2; g++) begin : g_err
    txq_err_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (err_set[g]),
      .clr_i  (err_clr),
      .flag_o (err_flag[g])
    );
  end

  assign overflow  = err_flag[0];
  assign underflow = err_flag[1];

endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          err_clr,
  input logic          rd_valid,
  input logic          empty,
  input logic          full,
  input logic [CW-1:0] fill_level,
  input logic          overflow,
  input logic          underflow
);

  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (fill_level == $past(fill_level)) && full);

  assert_overflow_raised_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  assert_underflow_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> (underflow && !rd_valid));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty) |=> rd_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !empty) |=> !rd_valid);

  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !empty && !full) |=> $stable(fill_level));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CW'(DEPTH));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !err_clr) |=> overflow);

  assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !err_clr) |=> underflow);

endmodule

bind txq_byte_fifo txq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .err_clr    (err_clr),
  .rd_valid   (rd_valid),
  .empty      (empty),
  .full       (full),
  .fill_level (fill_level),
  .overflow   (overflow),
  .underflow  (underflow)
);

// File: tb/sim_txq_byte_fifo.sv
module sim_txq_byte_fifo;

  localparam int DEPTH = 256;
  localparam int CW    = 9;

  logic          clk, rst_n;
  logic          wr_en, rd_en, err_clr;
  logic [7:0]    wr_data;
  logic [1:0]    wr_tag;
  logic [7:0]    rd_data;
  logic [1:0]    rd_tag;
  logic          rd_valid, empty, space_avail, full, overflow, underflow;
  logic [CW-1:0] space_thresh, fill_level;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [9:0] m_q[$];
  logic       m_ovf, m_udf, m_rv;
  logic [9:0] m_out;

  txq_byte_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .space_thresh(space_thresh), .err_clr(err_clr), .empty(empty),
    .space_avail(space_avail), .full(full), .fill_level(fill_level),
    .overflow(overflow), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic compare_all();
    int sz = m_q.size();
    chk("R9 fill_level", int'(fill_level), sz);
    chk("R5 empty", int'(empty), int'(sz == 0));
    chk("R5 full", int'(full), int'(sz == DEPTH));
    chk("R6 space_avail", int'(space_avail), int'((DEPTH - sz) >= int'(space_thresh)));
    chk("R3 overflow", int'(overflow), int'(m_ovf));
    chk("R4 underflow", int'(underflow), int'(m_udf));
    chk("R2 rd_valid", int'(rd_valid), int'(m_rv));
    if (m_rv) begin
      chk("R2 rd_data", int'(rd_data), int'(m_out[7:0]));
      chk("R2 rd_tag", int'(rd_tag), int'(m_out[9:8]));
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic w, input logic [7:0] d, input logic [1:0] t,
                      input logic r, input logic c);
    bit was_full, was_empty;
    wr_en = w; wr_data = d; wr_tag = t; rd_en = r; err_clr = c;
    @(posedge clk);
    was_full  = (m_q.size() == DEPTH);
    was_empty = (m_q.size() == 0);
    m_rv = 1'b0;
    if (r && !was_empty) begin
      m_out = m_q.pop_front();
      m_rv  = 1'b1;
    end
    if (w && !was_full) m_q.push_back({t, d});
    if (w && was_full) m_ovf = 1'b1;
    else if (c) m_ovf = 1'b0;
    if (r && was_empty) m_udf = 1'b1;
    else if (c) m_udf = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; err_clr = 0; wr_data = 0; wr_tag = 0;
    space_thresh = 9'd4;
    m_ovf = 0; m_udf = 0; m_rv = 0; m_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fill_level", int'(fill_level), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 underflow", int'(underflow), 0);

    // R2: ordered data and tags, reads back to back and spaced
    for (int i = 0; i < 5; i++) step(1, pat(i), 2'(i), 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);

    // R4: read while empty, R8: flag holds then clears
    step(0, 0, 0, 1, 0);
    chk("R4 no data on empty read", int'(rd_valid), 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    chk("R8 underflow held", int'(underflow), 1);
    step(0, 0, 0, 0, 1);
    chk("R8 underflow cleared", int'(underflow), 0);

    // R7: simultaneous read and write keeps the level
    for (int i = 0; i < 3; i++) step(1, pat(i + 50), 2'b01, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step(1, pat(i + 60), 2'(i), 1, 0);
      chk("R7 level held", int'(fill_level), 3);
    end
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);

    // R6 thresholds while empty
    space_thresh = 9'd256;
    step(0, 0, 0, 0, 0);
    chk("R6 threshold 256 empty", int'(space_avail), 1);
    step(1, 8'hA5, 2'b10, 0, 0);
    chk("R6 threshold 256 one stored", int'(space_avail), 0);
    space_thresh = 9'd0;
    step(0, 0, 0, 1, 0);

    // Fill to the top, threshold moved along the way
    space_thresh = 9'd100;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 200) space_thresh = 9'd1;
      step(1, pat(i + 100), 2'(i >> 3), 0, 0);
      if (i == 254) chk("R6 one free at threshold 1", int'(space_avail), 1);
    end
    chk("R5 full at DEPTH", int'(full), 1);
    chk("R6 none free", int'(space_avail), 0);
    chk("R9 level at DEPTH", int'(fill_level), DEPTH);

    // R3: writes into a full queue, alone and with a read
    step(1, 8'hEE, 2'b11, 0, 0);
    chk("R3 overflow raised", int'(overflow), 1);
    chk("R3 level kept", int'(fill_level), DEPTH);
    step(1, 8'hDD, 2'b11, 1, 0);
    step(1, pat(999), 2'b00, 0, 0);
    // R8: set and clear together keeps the flag
    step(1, 8'hCC, 2'b11, 0, 1);
    chk("R8 set wins over clear", int'(overflow), 1);
    step(0, 0, 0, 0, 1);
    chk("R8 overflow cleared", int'(overflow), 0);

    // Drain everything, then one read past empty
    space_thresh = 9'd0;
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0);
    chk("R5 empty after drain", int'(empty), 1);
    step(0, 0, 0, 1, 0);
    chk("R4 underflow after drain", int'(underflow), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule